// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is a listen-and-acknowledge slave on a two-wire serial bus made of a clock line and a data line. A bus master configures it with one fixed frame of ten bytes. The first byte is the device address, which includes the write direction bit. The next two bytes, a command code and a byte count, are clocked in and thrown away. The last seven bytes land, one each, in seven 8-bit configuration registers. The registers start from parameterised default values, so a system that never writes the block still has a valid configuration.

Both bus lines pass through a two-flop synchronizer into the system clock domain. Start, stop and clock edges are then detected on the synchronized lines. Bits are shifted in MSB first on the rising clock. During the ninth clock of every byte of a matching frame, the receiver pulls the data line low to acknowledge. When a data byte completes, its register takes the new value and a one-hot update strobe marks which register changed. A frame whose address does not match is left alone until the next start condition. A frame that is cut short keeps whatever data bytes had already arrived.

Top module: `cfgrx_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `cfg_bytes` equals the `DEFAULTS` parameter, `upd_stb` is all zero and `sda_pull_low` is 0.
- R2: A start condition is a falling data line while the clock line is high. A stop condition is a rising data line while the clock line is high. Bits are sampled on a rising clock, MSB first. Bytes clocked after a stop with no new start are neither acknowledged nor stored.
- R3: The first byte after a start must equal 8'hD2 exactly. Any other value gives no acknowledge, no strobe and no register change for the rest of that frame.
- R4: In a matching frame, the values of bytes 2 and 3 have no effect. Bytes 4 to 10 load registers 0 to 6 in that order, whatever the byte count says. Register k appears on `cfg_bytes[8k+7:8k]`.
- R5: Every bit of a written byte is stored and shown exactly as received, reserved bits included.
- R6: `upd_stb[k]` is high for exactly one cycle, and that cycle is the first cycle in which register k shows its new value. No more than one strobe bit is ever high at once, and `cfg_bytes` never changes without a strobe.
- R7: In a matching frame, `sda_pull_low` rises after the clock falls at the end of the eighth bit of each of the ten bytes. It stays high through the ninth clock and drops after that clock falls.
- R8: A stop or a repeated start before the tenth byte ends the frame. Registers already loaded keep their new values and the rest keep their old values. A repeated start begins a fresh frame that is checked in full.
- R9: Bytes after the tenth byte of a frame get no acknowledge and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pin (asynchronous) |
| sda_in | input | 1 | Serial data line as seen at the pin (asynchronous, wired-AND bus) |
| sda_pull_low | output | 1 | High while the receiver pulls the data line low to acknowledge |
| cfg_bytes | output | NREG*8 | Configuration registers; register k at bits 8k+7:8k |
| upd_stb | output | NREG | One-cycle one-hot strobe, bit k when register k is written |

## Verification
The assertions assume that each high and low phase of the serial clock lasts several system cycles, longer than the synchronizer delay plus one cycle. They also assume that the data line changes only while the clock is low, except at start and stop conditions. Under those two assumptions, acknowledge edges always fall inside a low clock phase, and a strobe is never followed at once by another. The bench master drives every phase as a multiple of five system cycles and changes data only in the low phase, so it stays inside both assumptions.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    // bytes consumed before the first data byte: address, command, count
    localparam int HDR_BYTES = 3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK,
        RX_SKIP
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] rx, input logic [7:0] dev);
        return rx == dev;
    endfunction

endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // idle bus lines are high, so reset to ones
    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '1;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '1;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgrx_cond.sv
module cfgrx_cond
    import cfgrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    always_comb begin
        ev.rise  = scl & ~scl_d;
        ev.fall  = ~scl & scl_d;
        ev.start = scl & scl_d & sda_d & ~sda;
        ev.stop  = scl & scl_d & ~sda_d & sda;
        ev.sda   = sda;
    end
endmodule

// File: rtl/cfgrx_ctrl.sv
module cfgrx_ctrl
    import cfgrx_pkg::*;
#(
    parameter int          NREG     = 7,
    parameter logic [7:0]  DEV_ADDR = 8'hD2,
    localparam int FRAME = HDR_BYTES + NREG,
    localparam int BW    = $clog2(FRAME + 1),
    localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      ev,
    output logic          ack,
    output logic          addr_ok,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data
);
    localparam logic [BW-1:0] HDR_B  = BW'(HDR_BYTES);
    localparam logic [BW-1:0] LAST_B = BW'(FRAME - 1);

    rx_state_e     state;
    logic [7:0]    shreg;
    logic [3:0]    bitcnt;
    logic [BW-1:0] byte_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            byte_idx <= '0;
            ack      <= 1'b0;
            addr_ok  <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state    <= RX_SHIFT;
                bitcnt   <= '0;
                byte_idx <= '0;
                addr_ok  <= 1'b0;
                ack      <= 1'b0;
            end else if (ev.stop) begin
                state   <= RX_IDLE;
                addr_ok <= 1'b0;
                ack     <= 1'b0;
            end else begin
                case (state)
                    RX_SHIFT: begin
                        if (ev.rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            if (byte_idx == '0) begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    addr_ok <= 1'b1;
                                    ack     <= 1'b1;
                                    state   <= RX_ACK;
                                end else begin
                                    state <= RX_SKIP;
                                end
                            end else if (byte_idx <= LAST_B) begin
                                ack   <= 1'b1;
                                state <= RX_ACK;
                                if (byte_idx >= HDR_B) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IW'(byte_idx - HDR_B);
                                    wr_data <= shreg;
                                end
                            end else begin
                                state <= RX_SKIP;
                            end
                        end
                    end
                    RX_ACK: begin
                        if (ev.fall) begin
                            ack      <= 1'b0;
                            state    <= RX_SHIFT;
                            bitcnt   <= '0;
                            byte_idx <= byte_idx + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgrx_top.sv
module cfgrx_top
    import cfgrx_pkg::*;
#(
    parameter int                NREG        = 7,
    parameter logic [7:0]        DEV_ADDR    = 8'hD2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [NREG*8-1:0] DEFAULTS    = 56'h5A_00_C3_FF_10_24_81,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic [NREG*8-1:0] cfg_bytes,
    output logic [NREG-1:0]   upd_stb
);
    logic [1:0]    bus_q;
    logic          scl_q;
    bus_evt_t      ev;
    logic          addr_ok;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;

    cfgrx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (bus_q)
    );

    assign scl_q = bus_q[1];

    cfgrx_cond u_cond (
        .clk (clk),
        .rst (rst),
        .scl (bus_q[1]),
        .sda (bus_q[0]),
        .ev  (ev)
    );

    cfgrx_ctrl #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .ack     (sda_pull_low),
        .addr_ok (addr_ok),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == IW'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_bytes[k*8 +: 8] <= DEFAULTS[k*8 +: 8];
                upd_stb[k]          <= 1'b0;
            end else begin
                upd_stb[k] <= hit;
                if (hit) cfg_bytes[k*8 +: 8] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/cfgrx_chk.sv
module cfgrx_chk #(
    parameter int                NREG     = 7,
    parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              ack,
    input logic              addr_ok,
    input logic [NREG*8-1:0] cfg_bytes,
    input logic [NREG-1:0]   upd_stb
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: state right after a reset of at least one cycle
    a_r1_reset_defaults: assert property (@(posedge clk)
        (rst_d && !rst) |-> (cfg_bytes == DEFAULTS && upd_stb == '0 && !ack));

    a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_stb));

    a_r6_change_has_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bytes) |-> (upd_stb != '0));

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        (upd_stb != '0) |=> (upd_stb == '0));

    a_r3_strobe_needs_match: assert property (@(posedge clk) disable iff (rst)
        (upd_stb != '0) |-> addr_ok);

    a_r3_ack_needs_match: assert property (@(posedge clk) disable iff (rst)
        ack |-> addr_ok);

    a_r7_ack_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> !scl_s);

    a_r7_ack_fall_scl_low: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !scl_s);
endmodule

bind cfgrx_top cfgrx_chk #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_q),
    .ack       (sda_pull_low),
    .addr_ok   (addr_ok),
    .cfg_bytes (cfg_bytes),
    .upd_stb   (upd_stb)
);

// File: tb/cfgrx_top_bench.sv
module cfgrx_top_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          NREG       = 7;
    localparam int          Q          = 5;
    localparam logic [7:0]  DEV        = 8'hD2;
    localparam logic [55:0] DEFS       = 56'h3C_99_0F_E1_42_00_A7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull_low;
    logic [NREG*8-1:0] cfg;
    logic [NREG-1:0]   stb;
    wire  sda_line = m_sda & ~sda_pull_low;

    cfgrx_top #(.NREG(NREG), .DEV_ADDR(DEV), .DEFAULTS(DEFS)) u_cfgrx_top (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (m_scl),
        .sda_in       (sda_line),
        .sda_pull_low (sda_pull_low),
        .cfg_bytes    (cfg),
        .upd_stb      (stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit [7:0] exp_regs [NREG];
    int exp_cnt  [NREG];
    int seen_cnt [NREG];
    int settle = 0;
    int m_idx  = 0;
    bit m_match  = 1'b0;
    bit m_active = 1'b0;

    function automatic logic [63:0] exp_flat();
        logic [63:0] v = '0;
        for (int k = 0; k < NREG; k++) v[k*8 +: 8] = exp_regs[k];
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int k = 0; k < NREG; k++) if (stb[k]) seen_cnt[k]++;
            if (stb != '0) check("R6 strobe one-hot", 64'($countones(stb)), 64'd1);
            if (settle > 0) settle--;
            else check("R4 registers every cycle", 64'(cfg), exp_flat());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d cycles expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic model_byte(input logic [7:0] b, output bit exp_ack, output string tag);
        if (!m_active) begin
            exp_ack = 1'b0;
            tag = "R2 no start";
        end else if (m_idx == 0) begin
            m_match = (b == DEV);
            exp_ack = m_match;
            tag = "R3 address";
        end else if (m_idx < 3 + NREG) begin
            exp_ack = m_match;
            tag = m_match ? "R7 ack" : "R3 ignored";
            if (m_match && m_idx >= 3) begin
                exp_regs[m_idx-3] = b;
                exp_cnt[m_idx-3]++;
                settle = 6;
            end
        end else begin
            exp_ack = 1'b0;
            tag = "R9 extra byte";
        end
        m_idx++;
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit ea;
        bit got;
        string tag;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            tick(Q);
            m_scl = 1'b1;
            tick(2*Q);
            m_scl = 1'b0;
            if (i == 0) model_byte(b, ea, tag);
            tick(Q);
        end
        m_sda = 1'b1;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        got = ~sda_line;
        tick(Q);
        m_scl = 1'b0;
        tick(Q);
        check({tag, " acknowledge"}, 64'(got), 64'(ea));
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b0;
        m_active = 1'b1;
        m_idx = 0;
        m_match = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        m_sda = 1'b1;
        m_active = 1'b0;
        tick(2*Q);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n,
                              input logic [55:0] d);
        bus_start();
        send_byte(a);
        send_byte(c);
        send_byte(n);
        for (int k = 0; k < NREG; k++) send_byte(d[k*8 +: 8]);
    endtask

    task automatic check_counts(input string req);
        for (int k = 0; k < NREG; k++)
            check({req, " strobe count"}, 64'(seen_cnt[k]), 64'(exp_cnt[k]));
        check({req, " final registers"}, 64'(cfg), exp_flat());
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) begin
            exp_regs[k] = DEFS[k*8 +: 8];
            exp_cnt[k]  = 0;
            seen_cnt[k] = 0;
        end
        tick(5);
        check("R1 defaults during reset", 64'(cfg), 64'(DEFS));
        rst = 1'b0;
        tick(1);
        check("R1 defaults after reset", 64'(cfg), 64'(DEFS));
        check("R1 no strobe", 64'(stb), 64'd0);
        check("R1 no ack", 64'(sda_pull_low), 64'd0);

        // R4 R5 R7: full frame, reserved bits written as ones
        send_frame(8'hD2, 8'hA5, 8'h07, 56'hFF_66_55_44_33_22_11);
        bus_stop();
        check_counts("R4 full frame");
        check("R5 all-ones byte kept", 64'(cfg[55:48]), 64'hFF);

        // R3: read-direction address and an unrelated address
        send_frame(8'hD3, 8'h00, 8'h07, 56'h00_00_00_00_00_00_00);
        bus_stop();
        check_counts("R3 address D3");
        send_frame(8'h52, 8'h00, 8'h07, 56'h12_34_56_78_9A_BC_DE);
        bus_stop();
        check_counts("R3 address 52");

        // R4: command and count values have no effect
        send_frame(8'hD2, 8'hFF, 8'h01, 56'h01_80_7E_C3_3C_00_F0);
        bus_stop();
        check_counts("R4 count ignored");

        // R8: stop after three data bytes
        bus_start();
        send_byte(8'hD2);
        send_byte(8'h10);
        send_byte(8'h07);
        send_byte(8'hAA);
        send_byte(8'hBB);
        send_byte(8'hCC);
        bus_stop();
        check_counts("R8 truncated by stop");

        // R8: repeated start after two data bytes, then a fresh frame
        bus_start();
        send_byte(8'hD2);
        send_byte(8'h00);
        send_byte(8'h07);
        send_byte(8'h5A);
        send_byte(8'hA5);
        check_counts("R8 before repeated start");
        send_frame(8'hD2, 8'h22, 8'h07, 56'h07_06_05_04_03_02_01);
        bus_stop();
        check_counts("R8 after repeated start");

        // R9: two bytes past the frame end
        send_frame(8'hD2, 8'h00, 8'h07, 56'h0E_0D_0C_0B_0A_09_08);
        send_byte(8'h77);
        send_byte(8'h88);
        bus_stop();
        check_counts("R9 extra bytes");

        // R2: bytes clocked with no start after a stop
        send_byte(8'hD2);
        send_byte(8'h00);
        send_byte(8'h07);
        send_byte(8'h55);
        check_counts("R2 no start");

        // R3: miss followed by a matching frame without a stop in between
        send_frame(8'hD0, 8'h00, 8'h07, 56'h11_11_11_11_11_11_11);
        send_frame(8'hD2, 8'h00, 8'h07, 56'h00_00_00_00_00_00_00);
        bus_stop();
        check_counts("R3 miss then match");

        tick(10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule